// File: doc/BRIEF.md
# Table-Driven Byte-Wide CRC Engine

This block computes a non-reflected CRC over a byte stream, absorbing one byte per clock. It first fills a 256-entry remainder table by itself, right after reset. Each entry is the modulo-2 remainder of one 8-bit dividend. The dividend is placed in the top byte of a CRC-wide register and divided bit by bit by the configured polynomial. Once the table is complete, the engine raises its table-valid flag and starts accepting bytes. Each byte needs one table lookup, one shift and one XOR.

Bytes arrive on a valid/ready stream. Two markers travel with each byte. A start marker reloads the remainder with the configured start value before that byte is absorbed. A last marker closes the message, and a one-cycle done pulse follows while the result is held on the output. The CRC width, the polynomial, the start value and the way the table is filled are all parameters. The fill runs either one division step per cycle or all eight steps of an entry in one cycle.

Top module: `crc_tbl_engine`

## Requirements
- R1: From reset until the table fill completes, `in_ready` and `tbl_ready` are low. Both rise after exactly 2048 clock cycles when FILL_MODE is serial (eight division steps per entry), or after 256 cycles when it is unrolled (one entry per cycle). They then stay high. Bytes offered before that are not absorbed, and `crc_out` stays 0.
- R2: Each table entry equals the bitwise modulo-2 division of its dividend, placed in the top byte, over eight MSB-first steps. So a one-byte message carrying both markers yields the bit-serial CRC of that byte taken from the start value.
- R3: For each absorbed byte, the index is the byte XORed with the top 8 bits of the remainder. The new remainder is the indexed entry XORed with the remainder shifted left by 8 and truncated to CRC_W. The result after the last byte equals the MSB-first bit-serial CRC. For the ASCII digits "123456789" that is 0xF4 (width 8, polynomial 0x07, start 0), 0x29B1 (16, 0x1021, 0xFFFF) and 0x0376E6E7 (32, 0x04C11DB7, 0xFFFFFFFF).
- R4: A byte with `in_first`=1 starts from INIT (default 0) instead of the held remainder. A byte without it continues from the held remainder, so a message split by idle gaps gives the same result as an unbroken one.
- R5: `crc_done` is high for exactly the one cycle after the clock edge that absorbs a byte with `in_last`=1. In that cycle `crc_out` holds the final remainder. `crc_done` is low at all other times.
- R6: A cycle with `in_valid`=0 has no effect: `crc_out` and `crc_done` do not respond to `in_data`, `in_first` or `in_last`.
- R7: CRC_W may be 8, 16 or 32, and POLY and INIT are CRC_W-bit parameters. Any other width, an even polynomial, or an unknown fill mode stops elaboration.
- R8: During reset, `crc_out`=0, `crc_done`=0, `in_ready`=0 and `tbl_ready`=0.
- R9: Once the table is valid, `in_ready` stays high and a byte is accepted on every cycle that `in_valid` is high, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | Engine can absorb a byte this cycle |
| in_data | input | 8 | Message byte |
| in_first | input | 1 | Byte opens a message; remainder reloaded from INIT |
| in_last | input | 1 | Byte closes a message |
| crc_out | output | CRC_W | Current remainder; final CRC while crc_done is high |
| crc_done | output | 1 | One-cycle pulse after the last byte is absorbed |
| tbl_ready | output | 1 | Remainder table is filled and valid |

## Verification
The bench builds three copies and drives them from one stimulus:
- width 8, polynomial 0x07, start 0, serial fill;
- width 16, polynomial 0x1021, start 0xFFFF, unrolled fill;
- width 32, polynomial 0x04C11DB7, start 0xFFFFFFFF, serial fill.

Together they cover both fill variants with their different ready times, the truncating shift that leaves nothing of the old remainder at width 8, and nonzero start values that make the start marker visible. A bit-serial model is compared against every copy on every clock. All 256 single-byte messages reach every table entry. The split message and the mid-stream restart test the marker handling against published check values.

// File: rtl/crc_tbl_pkg.sv
package crc_tbl_pkg;
   localparam int BYTE_W    = 8;
   localparam int TBL_DEPTH = 1 << BYTE_W;
   localparam int IDX_W     = $clog2(TBL_DEPTH);
   localparam int BIT_W     = $clog2(BYTE_W);

   typedef enum logic {
      FILL_SERIAL   = 1'b0,
      FILL_UNROLLED = 1'b1
   } fill_mode_e;
endpackage

// File: rtl/crc_tbl_fill.sv
module crc_tbl_fill
   import crc_tbl_pkg::*;
#(
   parameter int                CRC_W     = 8,
   parameter logic [CRC_W-1:0]  POLY      = CRC_W'(7),
   parameter fill_mode_e        FILL_MODE = FILL_SERIAL
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_addr,
   output logic [CRC_W-1:0]  wr_data,
   output logic              fill_done
);
   localparam int               PAD      = CRC_W - BYTE_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_DEPTH - 1);

   logic [IDX_W-1:0] addr_q;
   logic             done_q;

   function automatic logic [CRC_W-1:0] div_step(input logic [CRC_W-1:0] r);
      return r[CRC_W-1] ? ((r << 1) ^ POLY) : (r << 1);
   endfunction

   function automatic logic [CRC_W-1:0] seed(input logic [IDX_W-1:0] a);
      return CRC_W'(a) << PAD;
   endfunction

   assign wr_addr   = addr_q;
   assign fill_done = done_q;

   generate
      if (FILL_MODE == FILL_SERIAL) begin : g_serial
         localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
         logic [BIT_W-1:0] bit_q;
         logic [CRC_W-1:0] work_q;
         logic [CRC_W-1:0] step_w;

         assign step_w  = div_step(work_q);
         assign wr_en   = !done_q && (bit_q == LAST_BIT);
         assign wr_data = step_w;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               bit_q  <= '0;
               work_q <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               bit_q <= bit_q + 1'b1;
               if (bit_q == LAST_BIT) begin
                  work_q <= seed(addr_q + 1'b1);
                  addr_q <= addr_q + 1'b1;
                  if (addr_q == LAST_IDX) done_q <= 1'b1;
               end else begin
                  work_q <= step_w;
               end
            end
         end

         AST_FILL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> !wr_en); // R1
      end else begin : g_unrolled
         logic [CRC_W-1:0] entry_w;

         always_comb begin
            entry_w = seed(addr_q);
            for (int s = 0; s < BYTE_W; s++) entry_w = div_step(entry_w);
         end

         assign wr_en   = !done_q;
         assign wr_data = entry_w;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               addr_q <= addr_q + 1'b1;
               if (addr_q == LAST_IDX) done_q <= 1'b1;
            end
         end
      end
   endgenerate

   AST_FILL_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> !wr_en); // R1
   AST_FILL_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> fill_done); // R1
   AST_FILL_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != LAST_IDX) |=> (wr_addr == $past(wr_addr) + 1'b1)); // R2
endmodule

// File: rtl/crc_tbl_ram.sv
module crc_tbl_ram
   import crc_tbl_pkg::*;
#(
   parameter int CRC_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [CRC_W-1:0]  wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [CRC_W-1:0]  rdata
);
   logic [CRC_W-1:0] mem [TBL_DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/crc_tbl_step.sv
module crc_tbl_step
   import crc_tbl_pkg::*;
#(
   parameter int               CRC_W = 8,
   parameter logic [CRC_W-1:0] INIT  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              first,
   input  logic              last,
   input  logic [BYTE_W-1:0] data,
   output logic [IDX_W-1:0]  tbl_idx,
   input  logic [CRC_W-1:0]  tbl_entry,
   output logic [CRC_W-1:0]  rem,
   output logic              done
);
   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] base_w;
   logic [CRC_W-1:0] next_w;
   logic             done_q;

   assign base_w  = first ? INIT : rem_q;
   assign tbl_idx = data ^ base_w[CRC_W-1 -: BYTE_W];
   assign next_w  = tbl_entry ^ (base_w << BYTE_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         done_q <= 1'b0;
      end else begin
         if (acc) rem_q <= next_w;
         done_q <= acc && last;
      end
   end

   assign rem  = rem_q;
   assign done = done_q;

   AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(rem_q)); // R6
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(acc && last)); // R5
endmodule

// File: rtl/crc_tbl_engine.sv
module crc_tbl_engine
   import crc_tbl_pkg::*;
#(
   parameter int               CRC_W     = 8,
   parameter logic [CRC_W-1:0] POLY      = CRC_W'(7),
   parameter logic [CRC_W-1:0] INIT      = '0,
   parameter fill_mode_e       FILL_MODE = FILL_SERIAL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_first,
   input  logic              in_last,
   output logic [CRC_W-1:0]  crc_out,
   output logic              crc_done,
   output logic              tbl_ready
);
   generate
      if (!(CRC_W == 8 || CRC_W == 16 || CRC_W == 32)) begin : g_bad_width
         $error("crc_tbl_engine: CRC_W must be 8, 16 or 32"); // R7
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc_tbl_engine: POLY must have its constant term set"); // R7
      end
      if (!(FILL_MODE == FILL_SERIAL || FILL_MODE == FILL_UNROLLED)) begin : g_bad_mode
         $error("crc_tbl_engine: unknown FILL_MODE"); // R7
      end
   endgenerate

   logic              wr_en;
   logic [IDX_W-1:0]  wr_addr;
   logic [CRC_W-1:0]  wr_data;
   logic              fill_done;
   logic [IDX_W-1:0]  rd_idx;
   logic [CRC_W-1:0]  rd_entry;
   logic              accept;

   crc_tbl_fill #(
      .CRC_W     (CRC_W),
      .POLY      (POLY),
      .FILL_MODE (FILL_MODE)
   ) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .fill_done (fill_done)
   );

   crc_tbl_ram #(
      .CRC_W (CRC_W)
   ) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_idx),
      .rdata (rd_entry)
   );

   assign in_ready  = fill_done;
   assign tbl_ready = fill_done;
   assign accept    = in_valid && fill_done;

   crc_tbl_step #(
      .CRC_W (CRC_W),
      .INIT  (INIT)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (accept),
      .first     (in_first),
      .last      (in_last),
      .data      (in_data),
      .tbl_idx   (rd_idx),
      .tbl_entry (rd_entry),
      .rem       (crc_out),
      .done      (crc_done)
   );

   AST_DONE_NEEDS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done |-> tbl_ready); // R1
   AST_CRC_IDLE_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_ready |-> (crc_out == '0)); // R1
endmodule

// File: tb/sim_crc_tbl_engine.sv
module sim_crc_tbl_engine;
   import crc_tbl_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int ND = 3;
   localparam int          WID   [ND] = '{8, 16, 32};
   localparam logic [31:0] PLY   [ND] = '{32'h07, 32'h1021, 32'h04C11DB7};
   localparam logic [31:0] INI   [ND] = '{32'h0, 32'hFFFF, 32'hFFFF_FFFF};
   localparam int          FLEN  [ND] = '{2048, 256, 2048};
   localparam logic [31:0] KNOWN [ND] = '{32'hF4, 32'h29B1, 32'h0376_E6E7};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [7:0] in_data = 8'h00;

   logic [7:0]  c0;
   logic [15:0] c1;
   logic [31:0] c2;
   logic [ND-1:0] rdy, trdy, dn;
   logic [31:0] got [ND];

   always_comb begin
      got[0] = 32'(c0);
      got[1] = 32'(c1);
      got[2] = c2;
   end

   crc_tbl_engine u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .crc_out(c0), .crc_done(dn[0]), .tbl_ready(trdy[0]));

   crc_tbl_engine #(.CRC_W(16), .POLY(16'h1021), .INIT(16'hFFFF),
                    .FILL_MODE(FILL_UNROLLED)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .crc_out(c1), .crc_done(dn[1]), .tbl_ready(trdy[1]));

   crc_tbl_engine #(.CRC_W(32), .POLY(32'h04C11DB7), .INIT(32'hFFFF_FFFF),
                    .FILL_MODE(FILL_SERIAL)) u2 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .crc_out(c2), .crc_done(dn[2]), .tbl_ready(trdy[2]));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [31:0] m_rem  [ND] = '{0, 0, 0};
   logic        m_done [ND] = '{0, 0, 0};
   int          rise   [ND] = '{-1, -1, -1};

   function automatic logic [31:0] width_mask(input int w);
      return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction

   // Bit-serial, MSB-first reference division of one byte.
   function automatic logic [31:0] ref_byte(input logic [31:0] r, input logic [7:0] d,
                                            input int w, input logic [31:0] p);
      logic fb;
      for (int b = 7; b >= 0; b--) begin
         fb = r[w-1] ^ d[b];
         r  = (r << 1) & width_mask(w);
         if (fb) r = r ^ p;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Cycle model, advanced on each rising edge from the driven inputs.
   always @(posedge clk) begin
      if (!rst_n) begin
         cyc = 0;
         for (int k = 0; k < ND; k++) begin
            m_rem[k]  = 32'h0;
            m_done[k] = 1'b0;
         end
      end else begin
         for (int k = 0; k < ND; k++) begin
            automatic bit acc = in_valid && (cyc >= FLEN[k]);
            m_done[k] = acc && in_last;
            if (acc) m_rem[k] = ref_byte(in_first ? INI[k] : m_rem[k], in_data, WID[k], PLY[k]);
         end
         cyc++;
      end
   end

   // Per-clock comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int k = 0; k < ND; k++) begin
            check(got[k] == m_rem[k], "R3", "crc_out vs model", got[k], m_rem[k]);
            check(dn[k] == m_done[k], "R5", "crc_done vs model", 32'(dn[k]), 32'(m_done[k]));
            check(rdy[k] == (cyc >= FLEN[k]), "R1", "in_ready vs model",
                  32'(rdy[k]), 32'(cyc >= FLEN[k]));
            if (trdy[k] && rise[k] < 0) rise[k] = cyc;
         end
      end
   end

   task automatic send(input logic [7:0] d, input logic f, input logic l);
      in_valid = 1'b1;
      in_data  = d;
      in_first = f;
      in_last  = l;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog: got %0d cycles expected fewer than 20000", cyc);
         finish_run();
      end
   end

   initial begin
      logic [31:0] held [ND];
      repeat (3) @(negedge clk);
      for (int k = 0; k < ND; k++) begin // R8 reset state
         check(got[k] == 32'h0, "R8", "crc_out in reset", got[k], 32'h0);
         check(dn[k] == 1'b0, "R8", "crc_done in reset", 32'(dn[k]), 32'h0);
         check(rdy[k] == 1'b0, "R8", "in_ready in reset", 32'(rdy[k]), 32'h0);
         check(trdy[k] == 1'b0, "R8", "tbl_ready in reset", 32'(trdy[k]), 32'h0);
      end
      rst_n = 1'b1;

      // R1: bytes offered during the fill are not absorbed
      in_valid = 1'b1; in_data = 8'hA5; in_first = 1'b1; in_last = 1'b1;
      repeat (200) @(negedge clk);
      for (int k = 0; k < ND; k++)
         check(got[k] == 32'h0, "R1", "crc_out during fill", got[k], 32'h0);
      idle(1);
      while (cyc < 2050) @(negedge clk);
      for (int k = 0; k < ND; k++) begin
         check(rise[k] == FLEN[k], "R1", "fill length", 32'(rise[k]), 32'(FLEN[k]));
         check(trdy[k] == 1'b1, "R1", "tbl_ready after fill", 32'(trdy[k]), 32'h1);
      end

      // R2: every table entry through a one-byte message
      for (int d = 0; d < 256; d++) begin
         send(8'(d), 1'b1, 1'b1);
         for (int k = 0; k < ND; k++) begin
            check(got[k] == ref_byte(INI[k], 8'(d), WID[k], PLY[k]), "R2",
                  "single-byte crc", got[k], ref_byte(INI[k], 8'(d), WID[k], PLY[k]));
            check(dn[k] == 1'b1, "R5", "done after last", 32'(dn[k]), 32'h1);
         end
      end
      idle(1);
      for (int k = 0; k < ND; k++) begin
         check(dn[k] == 1'b0, "R5", "done one cycle only", 32'(dn[k]), 32'h0);
         held[k] = got[k];
      end

      // R6: markers and data without valid do nothing
      in_data = 8'h5A; in_first = 1'b1; in_last = 1'b1;
      repeat (4) @(negedge clk);
      for (int k = 0; k < ND; k++) begin
         check(got[k] == held[k], "R6", "crc_out held while idle", got[k], held[k]);
         check(dn[k] == 1'b0, "R6", "no done while idle", 32'(dn[k]), 32'h0);
      end

      // R3 R7 R9: check string, back to back, per width
      for (int i = 0; i < 9; i++) begin
         send(8'h31 + 8'(i), i == 0, i == 8);
         for (int k = 0; k < ND; k++)
            check(rdy[k] == 1'b1, "R9", "ready during burst", 32'(rdy[k]), 32'h1);
      end
      for (int k = 0; k < ND; k++)
         check(got[k] == KNOWN[k], "R3 R7", "check value", got[k], KNOWN[k]);
      idle(1);

      // R4: message split by an idle gap
      for (int i = 0; i < 4; i++) send(8'h31 + 8'(i), i == 0, 1'b0);
      idle(3);
      for (int k = 0; k < ND; k++)
         check(dn[k] == 1'b0, "R6", "no done mid message", 32'(dn[k]), 32'h0);
      for (int i = 4; i < 9; i++) send(8'h31 + 8'(i), 1'b0, i == 8);
      for (int k = 0; k < ND; k++)
         check(got[k] == KNOWN[k], "R4", "split message", got[k], KNOWN[k]);

      // R4: start marker discards an unfinished message
      send(8'h5A, 1'b1, 1'b0);
      send(8'hC3, 1'b0, 1'b0);
      for (int i = 0; i < 9; i++) send(8'h31 + 8'(i), i == 0, i == 8);
      for (int k = 0; k < ND; k++)
         check(got[k] == KNOWN[k], "R4", "restart by start marker", got[k], KNOWN[k]);
      idle(2);
      finish_run();
   end
endmodule